// File: doc/BRIEF.md
# Multi-Channel Interval Timer Unit

This block holds four counters behind one small register map. Three of them are down-counters of mixed width (16, 16 and 32 bits). Each one counts on a tick pulse it selects, either the slow one or the fast one. When it passes zero it raises its own interrupt line. In periodic mode the count then restarts from its load register; in free-running mode it wraps to all ones. The fourth counter is a 40-bit up-counter with no interrupt. It advances on every fast tick and serves as a timestamp. Software reads it in two word-sized halves, and the halves are always coherent.

Software programs a period of N ticks by loading N-1. Writing the load register also restarts the count at once. A write of any value to a channel's clear register drops its interrupt line. The tick inputs are single-cycle enable pulses made elsewhere, and the clock is the bus clock.

The bus is synchronous and takes word addresses. A write takes effect at the clock edge where the write strobe is high. Read data appears on the output one cycle after the read strobe and holds until the next read.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset every interrupt line is low and every readable register returns zero. This covers each channel's load, value and control registers, and both timestamp words.
- R2: Word address bits [5:2] select a channel: 0x0 selects channel 0, 0x2 channel 1 and 0x8 channel 2. Bits [1:0] then select the register: 0 load, 1 value, 2 control, 3 clear. Word address 0x18 is the timestamp low word and 0x19 the timestamp high word. Any other address, and the clear register, reads as zero, and a write there changes nothing. Read data is valid in the cycle after the read strobe.
- R3: A write to a channel's load register stores the value and puts it in the counter in the same edge. Reading the load register returns the stored value.
- R4: The channel control register reads back three bits: bit 7 enables counting, bit 6 selects periodic mode and bit 3 selects the fast tick. All other bits read as zero. While bit 7 is clear the count holds whatever ticks arrive.
- R5: An enabled channel decrements only on its selected tick, which is the fast tick when bit 3 is set and the slow tick otherwise. Pulses on the other tick have no effect.
- R6: In periodic mode a tick that finds the count at zero reloads it from the load register. A load of L therefore gives one underflow every L+1 ticks.
- R7: In free-running mode a tick that finds the count at zero sets it to all ones for the channel's width. That is 0xFFFF for channels 0 and 1, and 0xFFFFFFFF for channel 2.
- R8: Each underflow sets that channel's interrupt line, and the line stays high until a write of any value to the clear register. If an underflow and a clear write fall in the same cycle, the line stays high.
- R9: The 40-bit timestamp counts up by one on each fast tick while bit 8 of the high word is set. It holds while that bit is clear and ignores the slow tick.
- R10: Reading the timestamp low word returns count bits 31:0 and latches bits 39:32. Reading the high word returns the latched byte in bits 7:0 and the enable in bit 8.
- R11: Channel value and load registers read zero-extended to 32 bits. Channels 0 and 1 keep only the low 16 bits of a load write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | Slow tick-enable pulse |
| fastTick | input | 1 | Fast tick-enable pulse, also drives the timestamp |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busWordAddr | input | 6 | Word address of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| irq | output | 3 | Per-channel underflow interrupt |

## Verification
Assertions check several rules on every cycle:
- the step of each counter: reload, wrap, hold and immediate load;
- that an underflow sets the interrupt and that a clear lowers it;
- that the timestamp advances by exactly one per enabled fast tick;
- that at most one write strobe decodes at a time.

Other behaviour only the bench scenarios can show. These cover the period length over many random load and tick counts, the choice of tick source with pulses on the other tick, and the clear write that loses to a same-cycle underflow. They also cover the latched timestamp halves and isolation between channels at the bus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH    = 3;
  localparam int BUS_W     = 32;
  localparam int WADDR_W   = 6;
  localparam int CH_IDX_W  = 2;
  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_PER_BIT  = 6;
  localparam int CTRL_FAST_BIT = 3;
  localparam int TS_EN_BIT     = 8;
  localparam logic [WADDR_W-1:0] TS_LO_WADDR = 6'h18;
  localparam logic [WADDR_W-1:0] TS_HI_WADDR = 6'h19;

  typedef enum logic [2:0] {
    RD_NONE, RD_LOAD, RD_VALUE, RD_CTRL, RD_TSLO, RD_TSHI
  } rdSel_e;

  typedef struct packed {
    logic [NUM_CH-1:0]   loadWr;
    logic [NUM_CH-1:0]   ctrlWr;
    logic [NUM_CH-1:0]   clrWr;
    logic                tsCtrlWr;
    logic                rdEn;
    rdSel_e              rdSel;
    logic [CH_IDX_W-1:0] rdChan;
  } strobes_t;

  // Upper nibble of the word address for each channel
  function automatic logic [3:0] chanBaseHi(int i);
    case (i)
      0:       return 4'h0;
      1:       return 4'h2;
      default: return 4'h8;
    endcase
  endfunction
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [WADDR_W-1:0] busWordAddr,
  output strobes_t           strb
);
  logic                hitCh;
  logic [CH_IDX_W-1:0] chIdx;

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_NONE;
    strb.rdEn   = busRdEn;
    hitCh       = 1'b0;
    chIdx       = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (busWordAddr[5:2] == chanBaseHi(i)) begin
        hitCh = 1'b1;
        chIdx = CH_IDX_W'(i);
      end
    end
    if (hitCh) begin
      strb.rdChan = chIdx;
      case (busWordAddr[1:0])
        2'd0: begin strb.loadWr[chIdx] = busWrEn; strb.rdSel = RD_LOAD; end
        2'd1: strb.rdSel = RD_VALUE;
        2'd2: begin strb.ctrlWr[chIdx] = busWrEn; strb.rdSel = RD_CTRL; end
        default: strb.clrWr[chIdx] = busWrEn;
      endcase
    end else if (busWordAddr == TS_LO_WADDR) begin
      strb.rdSel = RD_TSLO;
    end else if (busWordAddr == TS_HI_WADDR) begin
      strb.tsCtrlWr = busWrEn;
      strb.rdSel    = RD_TSHI;
    end
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadWr, strb.ctrlWr, strb.clrWr, strb.tsCtrlWr}));

  // R2
  no_write_without_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> ({strb.loadWr, strb.ctrlWr, strb.clrWr, strb.tsCtrlWr} == '0));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         slowTick,
  input  logic         fastTick,
  input  logic         loadWr,
  input  logic         ctrlWr,
  input  logic         clrWr,
  input  logic [W-1:0] loadData,
  input  logic [2:0]   ctrlData,   // {enable, periodic, fastSel}
  output logic [W-1:0] loadVal,
  output logic [W-1:0] countVal,
  output logic [2:0]   ctrlVal,
  output logic         irq
);
  logic         en, periodic, fastSel;
  logic [W-1:0] loadReg, count;
  logic         tick, atZero, underflow;

  assign tick      = en && (fastSel ? fastTick : slowTick);
  assign atZero    = (count == '0);
  assign underflow = tick && atZero && !loadWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en <= 1'b0; periodic <= 1'b0; fastSel <= 1'b0;
      loadReg <= '0; count <= '0; irq <= 1'b0;
    end else begin
      if (ctrlWr) begin
        en       <= ctrlData[2];
        periodic <= ctrlData[1];
        fastSel  <= ctrlData[0];
      end
      if (loadWr) begin
        loadReg <= loadData;
        count   <= loadData;
      end else if (tick) begin
        if (atZero) count <= periodic ? loadReg : '1;
        else        count <= count - 1'b1;
      end
      if (underflow)  irq <= 1'b1;
      else if (clrWr) irq <= 1'b0;
    end
  end

  assign loadVal  = loadReg;
  assign countVal = count;
  assign ctrlVal  = {en, periodic, fastSel};

  // R3
  load_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |=> count == $past(loadData));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !loadWr) |=> $stable(count));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && periodic) |=> count == $past(loadReg));
  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !periodic) |=> &count);
  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> irq);
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !underflow) |=> !irq);
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrWr) |=> irq);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CH0_W = 16,
  parameter int CH1_W = 16,
  parameter int CH2_W = 32,
  parameter int TS_W  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              fastTick,
  input  strobes_t          strb,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  output logic [NUM_CH-1:0] irq
);
  localparam int TS_HI_W = TS_W - BUS_W;

  function automatic int chanWidth(int i);
    case (i)
      0:       return CH0_W;
      1:       return CH1_W;
      default: return CH2_W;
    endcase
  endfunction

  logic [BUS_W-1:0] loadPad  [NUM_CH];
  logic [BUS_W-1:0] countPad [NUM_CH];
  logic [BUS_W-1:0] ctrlPad  [NUM_CH];
  logic [2:0]       ctrlData;

  assign ctrlData = {busWrData[CTRL_EN_BIT], busWrData[CTRL_PER_BIT], busWrData[CTRL_FAST_BIT]};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    localparam int CW = chanWidth(i);
    logic [CW-1:0] loadVal, countVal;
    logic [2:0]    ctrlVal;

    tmr_chan #(.W(CW)) u_chan (
      .clk(clk), .rstN(rstN), .slowTick(slowTick), .fastTick(fastTick),
      .loadWr(strb.loadWr[i]), .ctrlWr(strb.ctrlWr[i]), .clrWr(strb.clrWr[i]),
      .loadData(busWrData[CW-1:0]), .ctrlData(ctrlData),
      .loadVal(loadVal), .countVal(countVal), .ctrlVal(ctrlVal), .irq(irq[i])
    );

    always_comb begin
      loadPad[i]            = '0;
      loadPad[i][CW-1:0]    = loadVal;
      countPad[i]           = '0;
      countPad[i][CW-1:0]   = countVal;
      ctrlPad[i]            = '0;
      ctrlPad[i][CTRL_EN_BIT]   = ctrlVal[2];
      ctrlPad[i][CTRL_PER_BIT]  = ctrlVal[1];
      ctrlPad[i][CTRL_FAST_BIT] = ctrlVal[0];
    end
  end

  // Timestamp counter
  logic [TS_W-1:0]    tsCount;
  logic               tsEn;
  logic [TS_HI_W-1:0] tsHiLatch;
  logic [BUS_W-1:0]   tsHiWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsCount <= '0;
      tsEn    <= 1'b0;
    end else begin
      if (strb.tsCtrlWr) tsEn <= busWrData[TS_EN_BIT];
      if (tsEn && fastTick) tsCount <= tsCount + 1'b1;
    end
  end

  always_comb begin
    tsHiWord                = '0;
    tsHiWord[TS_HI_W-1:0]   = tsHiLatch;
    tsHiWord[TS_EN_BIT]     = tsEn;
  end

  // Registered read port with coherent timestamp capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData <= '0;
      tsHiLatch <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        RD_LOAD:  busRdData <= loadPad[strb.rdChan];
        RD_VALUE: busRdData <= countPad[strb.rdChan];
        RD_CTRL:  busRdData <= ctrlPad[strb.rdChan];
        RD_TSLO: begin
          busRdData <= tsCount[BUS_W-1:0];
          tsHiLatch <= tsCount[TS_W-1:BUS_W];
        end
        RD_TSHI:  busRdData <= tsHiWord;
        default:  busRdData <= '0;
      endcase
    end
  end

  // R9
  ts_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tsEn && fastTick) |=> tsCount == $past(tsCount) + TS_W'(1));
  // R9
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(tsEn && fastTick) |=> $stable(tsCount));
  // R10
  ts_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == RD_TSLO) |=> tsHiLatch == $past(tsCount[TS_W-1:BUS_W]));
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tmr_pkg::*;
#(
  parameter int CH0_W = 16,
  parameter int CH1_W = 16,
  parameter int CH2_W = 32,
  parameter int TS_W  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              fastTick,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [WADDR_W-1:0] busWordAddr,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  output logic [NUM_CH-1:0] irq
);
  strobes_t strb;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWordAddr(busWordAddr), .strb(strb)
  );

  tmr_datapath #(.CH0_W(CH0_W), .CH1_W(CH1_W), .CH2_W(CH2_W), .TS_W(TS_W)) u_dp (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .fastTick(fastTick),
    .strb(strb), .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );
endmodule

// File: tb/sim_tick_timer_unit.sv
`timescale 1ns/1ps
module sim_tick_timer_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b0, fastTick = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [5:0]  busWordAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [2:0]  irq;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;   // 250 MHz

  tick_timer_unit u0 (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .fastTick(fastTick),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWordAddr(busWordAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  // ---------------- reference functions ----------------
  function automatic int chWidth(int ch);
    return (ch == 2) ? 32 : 16;
  endfunction
  function automatic logic [5:0] chWord(int ch, int reg_i);
    logic [3:0] hi;
    hi = (ch == 0) ? 4'h0 : (ch == 1) ? 4'h2 : 4'h8;
    return {hi, 2'(reg_i)};
  endfunction
  function automatic longint unsigned expCount(longint unsigned l, longint unsigned k,
                                               bit periodic, int w);
    longint unsigned mask;
    mask = (64'd1 << w) - 1;
    if (k <= l)   return l - k;
    if (periodic) return l - (k % (l + 1));
    return (mask - (k - l - 1)) & mask;
  endfunction
  function automatic bit expIrq(longint unsigned l, longint unsigned k);
    return k >= l + 1;
  endfunction

  // ---------------- tasks ----------------
  task automatic chk(string req, longint unsigned act, longint unsigned expv);
    nChecks++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic busWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk); busWrEn = 1'b1; busWordAddr = a; busWrData = d;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); busRdEn = 1'b1; busWordAddr = a;
    @(negedge clk); busRdEn = 1'b0; d = busRdData;
  endtask

  task automatic pulse(bit fast);
    @(negedge clk); if (fast) fastTick = 1'b1; else slowTick = 1'b1;
    @(negedge clk); fastTick = 1'b0; slowTick = 1'b0;
  endtask

  task automatic runChan(int ch, int l, int k, bit periodic, bit fast);
    logic [31:0] rd, ctrlWord;
    ctrlWord = 32'h80 | (32'(periodic) << 6) | (32'(fast) << 3);
    busWrite(chWord(ch, 2), 32'h0);
    busWrite(chWord(ch, 0), 32'(l));
    busWrite(chWord(ch, 3), $urandom);
    busWrite(chWord(ch, 2), ctrlWord | 32'h0000_0F37 & ~32'h0000_00C8);
    busRead(chWord(ch, 2), rd);
    chk("R4 ctrl readback", rd, ctrlWord);
    for (int t = 0; t < k; t++) begin
      pulse(fast);
      if ($urandom % 2) pulse(!fast);   // R5: other tick ignored
    end
    busWrite(chWord(ch, 2), 32'h0);
    busRead(chWord(ch, 1), rd);
    chk(periodic ? "R6 periodic count" : "R7 free count", rd,
        expCount(l, k, periodic, chWidth(ch)));
    chk("R8 irq after run", irq[ch], expIrq(l, k));
    busRead(chWord(ch, 0), rd);
    chk("R3 load readback", rd, l);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 irq", irq, 3'b000);
    for (int ch = 0; ch < 3; ch++) begin
      for (int r = 0; r < 3; r++) begin
        busRead(chWord(ch, r), rd);
        chk("R1 reg zero", rd, 0);
      end
    end
    busRead(6'h18, rd); chk("R1 ts low", rd, 0);
    busRead(6'h19, rd); chk("R1 ts high", rd, 0);

    // R2: unmapped and clear addresses read zero; channel isolation
    busWrite(chWord(0, 0), 32'h1234);
    busWrite(chWord(1, 0), 32'h0055);
    busWrite(6'h10, 32'hFFFF_FFFF);
    busRead(6'h10, rd);          chk("R2 unmapped reads zero", rd, 0);
    busRead(chWord(0, 3), rd);   chk("R2 clear reg reads zero", rd, 0);
    busRead(chWord(1, 1), rd);   chk("R2 channel isolation", rd, 32'h55);
    busRead(chWord(0, 1), rd);   chk("R2 ch0 value", rd, 32'h1234);
    busRead(chWord(2, 1), rd);   chk("R2 ch2 untouched", rd, 0);

    // R11: width truncation and zero extension
    busWrite(chWord(1, 0), 32'hABCD_9876);
    busRead(chWord(1, 0), rd);   chk("R11 16-bit load truncated", rd, 32'h9876);
    busWrite(chWord(2, 0), 32'hABCD_9876);
    busRead(chWord(2, 0), rd);   chk("R11 32-bit load kept", rd, 32'hABCD_9876);

    // R7/R11: wrap values per width
    runChan(0, 0, 1, 1'b0, 1'b0);
    runChan(2, 0, 1, 1'b0, 1'b1);
    runChan(1, 2, 5, 1'b0, 1'b0);

    // R4: disabled counter holds
    busWrite(chWord(0, 2), 32'h0);
    busWrite(chWord(0, 0), 32'd9);
    for (int t = 0; t < 4; t++) begin pulse(1'b0); pulse(1'b1); end
    busRead(chWord(0, 1), rd);   chk("R4 disabled holds", rd, 9);

    // R5: slow-selected channel ignores fast ticks only
    busWrite(chWord(0, 2), 32'h80);
    for (int t = 0; t < 3; t++) pulse(1'b1);
    busRead(chWord(0, 1), rd);   chk("R5 fast ignored on slow select", rd, 9);
    pulse(1'b0);
    busRead(chWord(0, 1), rd);   chk("R5 slow counts", rd, 8);

    // R3: load write while running takes effect at once
    busWrite(chWord(0, 2), 32'hC0);
    busWrite(chWord(0, 0), 32'd50);
    busRead(chWord(0, 1), rd);   chk("R3 immediate load", rd, 50);
    pulse(1'b0);
    busRead(chWord(0, 1), rd);   chk("R3 count after reload", rd, 49);

    // R6: exact period boundary (load 3 => irq on 4th tick)
    busWrite(chWord(1, 2), 32'h0);
    busWrite(chWord(1, 0), 32'd3);
    busWrite(chWord(1, 3), 32'h0);
    busWrite(chWord(1, 2), 32'hC0);
    for (int t = 0; t < 3; t++) pulse(1'b0);
    chk("R6 no irq before period end", irq[1], 0);
    pulse(1'b0);
    chk("R6 irq at period end", irq[1], 1);
    busRead(chWord(1, 1), rd);   chk("R6 reloaded", rd, 3);

    // R8: clear, then clear colliding with underflow
    busWrite(chWord(1, 3), 32'hDEAD);
    chk("R8 clear drops irq", irq[1], 0);
    busWrite(chWord(1, 0), 32'd0);
    @(negedge clk); busWrEn = 1'b1; busWordAddr = chWord(1, 3); busWrData = 32'h1; slowTick = 1'b1;
    @(negedge clk); busWrEn = 1'b0; slowTick = 1'b0;
    chk("R8 underflow wins over clear", irq[1], 1);
    busWrite(chWord(1, 2), 32'h0);
    busWrite(chWord(1, 3), 32'h0);
    chk("R8 later clear drops irq", irq[1], 0);

    // Random runs
    for (int it = 0; it < 40; it++) begin
      int ch, l, k;
      bit per, fst;
      ch  = $urandom % 3;
      l   = $urandom % 24;
      k   = $urandom % 60;
      per = $urandom % 2;
      fst = $urandom % 2;
      runChan(ch, l, k, per, fst);
    end

    // R9/R10: timestamp
    for (int t = 0; t < 5; t++) pulse(1'b1);
    busRead(6'h18, rd);          chk("R9 disabled timestamp holds", rd, 0);
    busWrite(6'h19, 32'h100);
    for (int t = 0; t < 7; t++) begin pulse(1'b1); pulse(1'b0); end
    busRead(6'h18, rd);          chk("R9 counts fast ticks", rd, 7);
    busRead(6'h19, rd);          chk("R10 high word with enable", rd, 32'h100);
    busWrite(6'h19, 32'h0);
    pulse(1'b1);
    busRead(6'h18, rd);          chk("R9 stops when disabled", rd, 7);
    busRead(6'h19, rd);          chk("R10 high word enable clear", rd, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule